// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block compares each bus address against eight chip-select windows that software sets up. It then drives one active-low select line for the window that matches. Each window holds four settings:

- a base address
- an address mask, which sets the window size anywhere from 64 KB to 4 GB
- a port-size code
- a wait-state count

When an access hits a window, the select goes low for the whole access. The block counts the programmed wait states and then raises a one-cycle transfer acknowledge.

Two requesters can start an access: the internal core and an external bus master. While idle, the block serves the internal request if one is pending. Otherwise it serves the external one. It reports on a separate output which master owns the current access. Windows are loaded through a simple write port, one whole window per write. An access that is in progress keeps the settings it latched when it started.

Top module: `cs_decoder`

## Requirements
- R1: While rst_ni is low and after reset, cs_no is all ones, ta_o and ext_own_o are 0 and psize_o is 2'b00. All windows reset to not valid.
- R2: Window i matches when its valid bit is set and address bits [31:16] equal its base on every bit where its mask is 0. Address bits [15:0] never take part in the comparison.
- R3: A mask bit of 1 excludes that address bit from the match. A mask of 16'h0000 gives a 64 KB window, and a mask of 16'hFFFF matches every address (4 GB).
- R4: A window whose valid bit is 0 never drives its select, even when the address matches it.
- R5: If several windows match, the lowest-numbered one is selected. At most one bit of cs_no is ever 0.
- R6: The request is first sampled high while idle at rising edge k, and the hit window has wait count N. The select is low from edge k on, and ta_o is high for exactly the one cycle that follows edge k+N. The select returns high at edge k+N+1.
- R7: While a select is low, psize_o carries that window's 2-bit port code: 2'b00 = 32-bit, 2'b01 = 8-bit, 2'b10 = 16-bit. psize_o is 2'b00 while idle.
- R8: When int_req_i is low, ext_req_i starts an access decoded from ext_addr_i, and ext_own_o is high for that whole access. ext_own_o is 0 during internal accesses.
- R9: If int_req_i and ext_req_i are both high while idle, the internal access is served first. A held external request is served starting with the second edge after the internal acknowledge.
- R10: An address that matches no valid window asserts no select and no acknowledge, and the block stays idle.
- R11: A pulse on cfg_we_i loads window cfg_idx_i at that clock edge. Accesses that start later use the new values. An access already in progress keeps the wait count, port size and select it latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Window write strobe |
| cfg_idx_i | input | 3 | Index of the window to write |
| cfg_valid_i | input | 1 | Valid bit written to the window |
| cfg_base_i | input | 16 | Base address bits [31:16] |
| cfg_mask_i | input | 16 | Mask for address bits [31:16], 1 = ignore |
| cfg_ws_i | input | 4 | Wait-state count |
| cfg_psize_i | input | 2 | Port-size code |
| int_req_i | input | 1 | Internal core access request, held until acknowledge |
| int_addr_i | input | 32 | Internal access address |
| ext_req_i | input | 1 | External master access request, held until acknowledge |
| ext_addr_i | input | 32 | External access address |
| cs_no | output | 8 | Active-low chip selects |
| psize_o | output | 2 | Port size of the active window |
| ta_o | output | 1 | Transfer acknowledge, one cycle |
| ext_own_o | output | 1 | Current access belongs to the external master |

## Verification
An internal and an external request can arrive in the same idle cycle. Both are raised on the same falling edge with addresses that hit different windows. The bench checks three things: the internal access runs with ext_own_o low and its own window's timing, one idle cycle follows, and then the external access runs with its own wait count and port code. A configuration write can also land in the same cycle as a running access. This case is provoked by rewriting the active window in mid-access, and it is judged by an acknowledge time and port code that stay unchanged, while the next access to that window uses the new values.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned CMP_LSB = 16;
  localparam int unsigned CMP_W   = ADDR_W - CMP_LSB;
  localparam int unsigned WS_W    = 4;

  typedef enum logic [1:0] {
    PS_32 = 2'b00,
    PS_8  = 2'b01,
    PS_16 = 2'b10
  } psize_e;

  typedef struct packed {
    logic             valid;
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] mask;
    logic [WS_W-1:0]  ws;
    psize_e           ps;
  } win_cfg_t;
endpackage

// File: rtl/cs_win_match.sv
module cs_win_match
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 8
) (
  input  logic [CMP_W-1:0] addr_hi_i,
  input  win_cfg_t         cfg_i [NUM_CS],
  output logic [NUM_CS-1:0] hit_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign hit_o[g] = cfg_i[g].valid &&
                      (((addr_hi_i ^ cfg_i[g].base) & ~cfg_i[g].mask) == '0);
  end
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] hit_i,
  output logic [NUM_CS-1:0] onehot_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  // lowest set bit wins
  assign onehot_o = hit_i & (~hit_i + 1'b1);
  assign any_o    = |hit_i;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cs_wait_fsm.sv
module cs_wait_fsm
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic              ext_i,
  input  logic [NUM_CS-1:0] sel_i,
  input  logic [WS_W-1:0]   ws_i,
  input  psize_e            ps_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic [1:0]        psize_o,
  output logic              ta_o,
  output logic              ext_own_o
);
  logic              busy_q;
  logic [WS_W-1:0]   cnt_q;
  logic [NUM_CS-1:0] sel_q;
  psize_e            ps_q;
  logic              ext_q;
  logic              start, done;

  assign start = !busy_q && req_i && hit_i;
  assign done  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      ps_q   <= PS_32;
      ext_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= ws_i;
      sel_q  <= sel_i;
      ps_q   <= ps_i;
      ext_q  <= ext_i;
    end else if (done) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      ps_q   <= PS_32;
      ext_q  <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cs_no     = ~sel_q;
  assign psize_o   = ps_q;
  assign ta_o      = done;
  assign ext_own_o = ext_q;
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [CMP_W-1:0]  cfg_base_i,
  input  logic [CMP_W-1:0]  cfg_mask_i,
  input  logic [WS_W-1:0]   cfg_ws_i,
  input  logic [1:0]        cfg_psize_i,
  input  logic              int_req_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic              ext_req_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic [1:0]        psize_o,
  output logic              ta_o,
  output logic              ext_own_o
);
  win_cfg_t          win_q [NUM_CS];
  logic              use_ext;
  logic [CMP_W-1:0]  addr_hi;
  logic [NUM_CS-1:0] hit, sel;
  logic [IDX_W-1:0]  sel_idx;
  logic              any_hit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[g] <= '0;
      end else if (cfg_we_i && cfg_idx_i == IDX_W'(g)) begin
        win_q[g].valid <= cfg_valid_i;
        win_q[g].base  <= cfg_base_i;
        win_q[g].mask  <= cfg_mask_i;
        win_q[g].ws    <= cfg_ws_i;
        win_q[g].ps    <= psize_e'(cfg_psize_i);
      end
    end
  end

  // internal master has priority when idle
  assign use_ext = !int_req_i;
  assign addr_hi = use_ext ? ext_addr_i[ADDR_W-1:CMP_LSB]
                           : int_addr_i[ADDR_W-1:CMP_LSB];

  cs_win_match #(.NUM_CS(NUM_CS)) u_match (
    .addr_hi_i (addr_hi),
    .cfg_i     (win_q),
    .hit_o     (hit)
  );

  cs_prio_pick #(.NUM_CS(NUM_CS)) u_prio (
    .hit_i    (hit),
    .onehot_o (sel),
    .idx_o    (sel_idx),
    .any_o    (any_hit)
  );

  cs_wait_fsm #(.NUM_CS(NUM_CS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (int_req_i | ext_req_i),
    .hit_i     (any_hit),
    .ext_i     (use_ext),
    .sel_i     (sel),
    .ws_i      (win_q[sel_idx].ws),
    .ps_i      (win_q[sel_idx].ps),
    .cs_no     (cs_no),
    .psize_o   (psize_o),
    .ta_o      (ta_o),
    .ext_own_o (ext_own_o)
  );
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
  parameter int unsigned NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_req_i,
  input logic [NUM_CS-1:0] cs_no,
  input logic [1:0]        psize_o,
  input logic              ta_o,
  input logic              ext_own_o
);
  logic active;
  assign active = |(~cs_no);

  p_one_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  p_ta_with_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> active);

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !active);

  p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !ta_o) |=> $stable(cs_no));

  p_ps_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !ta_o) |=> $stable(psize_o));

  p_idle_ps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (psize_o == 2'b00));

  p_ext_own_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_own_o |-> active);

  p_int_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !$past(active) && $past(int_req_i)) |-> !ext_own_o);
endmodule

bind cs_decoder cs_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .int_req_i (int_req_i),
  .cs_no     (cs_no),
  .psize_o   (psize_o),
  .ta_o      (ta_o),
  .ext_own_o (ext_own_o)
);

// File: tb/cs_decoder_bench.sv
module cs_decoder_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [15:0] cfg_base = '0, cfg_mask = '0;
  logic [3:0]  cfg_ws = '0;
  logic [1:0]  cfg_ps = '0;
  logic        int_req = 1'b0, ext_req = 1'b0;
  logic [31:0] int_addr = '0, ext_addr = '0;
  logic [N-1:0] cs_n;
  logic [1:0]  psize;
  logic        ta, ext_own;

  always #5 clk = ~clk;

  cs_decoder u_cs_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_valid_i(cfg_valid), .cfg_base_i(cfg_base), .cfg_mask_i(cfg_mask),
    .cfg_ws_i(cfg_ws), .cfg_psize_i(cfg_ps), .int_req_i(int_req),
    .int_addr_i(int_addr), .ext_req_i(ext_req), .ext_addr_i(ext_addr),
    .cs_no(cs_n), .psize_o(psize), .ta_o(ta), .ext_own_o(ext_own)
  );

  int n_chk = 0, n_bad = 0;
  bit m_v [N];
  logic [15:0] m_b [N], m_m [N];
  int m_ws [N];
  logic [1:0] m_ps [N];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_win(logic [31:0] a);
    for (int i = 0; i < N; i++)
      if (m_v[i] && (((a[31:16] ^ m_b[i]) & ~m_m[i]) == 16'h0)) return i;
    return -1;
  endfunction

  task automatic cfg_write(int i, bit v, logic [15:0] b, logic [15:0] m, int ws, logic [1:0] ps);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_valid = v; cfg_base = b;
    cfg_mask = m; cfg_ws = 4'(ws); cfg_ps = ps;
    @(negedge clk);
    cfg_we = 1'b0;
    m_v[i] = v; m_b[i] = b; m_m[i] = m; m_ws[i] = ws; m_ps[i] = ps;
  endtask

  task automatic check_idle(string tag);
    chk(cs_n == '1, tag, "idle cs_n", cs_n, 8'hFF);
    chk(ta == 1'b0, tag, "idle ta", ta, 0);
    chk(psize == 2'b00, tag, "idle psize", psize, 0);
  endtask

  // samples after edges k .. k+ws; returns at the acknowledge negedge
  task automatic run_phase(int w, int ws, logic [1:0] ps, bit ext, string tag);
    for (int c = 0; c <= ws; c++) begin
      @(negedge clk);
      chk(cs_n == ~(8'(1) << w), tag, "cs_n", cs_n, ~(8'(1) << w));
      chk(ta == (c == ws), tag, "ta", ta, (c == ws));
      chk(psize == ps, tag, "psize", psize, ps);
      chk(ext_own == ext, tag, "ext_own", ext_own, ext);
    end
  endtask

  task automatic access(bit ext, logic [31:0] a, string tag);
    int w;
    w = exp_win(a);
    @(negedge clk);
    if (ext) begin ext_req = 1'b1; ext_addr = a; int_addr = ~a; end
    else begin int_req = 1'b1; int_addr = a; ext_addr = ~a; end
    if (w < 0) begin
      repeat (3) begin
        @(negedge clk);
        check_idle(tag);
      end
    end else begin
      run_phase(w, m_ws[w], m_ps[w], ext, tag);
    end
    int_req = 1'b0; ext_req = 1'b0;
    @(negedge clk);
    check_idle(tag);
  endtask

  task automatic sweep(string tag);
    logic [7:0] xs [3];
    xs[0] = 8'h00; xs[1] = 8'h34; xs[2] = 8'hFF;
    for (int b = 0; b < 256; b++)
      for (int xi = 0; xi < 3; xi++)
        access(bit'((b + xi) % 2), {8'(b), xs[xi], 8'(b) ^ 8'hA5, 8'(b)}, tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_b[i] = '0; m_m[i] = '0; m_ws[i] = 0; m_ps[i] = '0;
    end
    repeat (2) @(negedge clk);
    check_idle("R1");
    chk(ext_own == 1'b0, "R1", "ext_own", ext_own, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    // R1: windows reset invalid -> any address misses
    access(1'b0, 32'h1234_5678, "R1");

    cfg_write(0, 1, 16'h1000, 16'h0000, 0, 2'b01);
    cfg_write(1, 1, 16'h1000, 16'h00FF, 2, 2'b10);
    cfg_write(2, 0, 16'h2034, 16'h0000, 1, 2'b01);
    cfg_write(3, 1, 16'h2000, 16'h00FF, 7, 2'b00);
    cfg_write(4, 1, 16'h8000, 16'h7FFF, 3, 2'b01);
    cfg_write(5, 1, 16'h4100, 16'h0AFF, 1, 2'b10);
    cfg_write(6, 0, 16'h0000, 16'hFFFF, 4, 2'b00);
    cfg_write(7, 1, 16'hFFFF, 16'h0000, 5, 2'b01);

    // directed corners
    access(1'b0, 32'h1000_FFFF, "R2");
    access(1'b0, 32'h1001_0000, "R3");
    access(1'b0, 32'hFFFF_0000, "R3");
    access(1'b0, 32'h2034_0000, "R4");
    access(1'b0, 32'h1000_0000, "R5");
    access(1'b0, 32'h4F34_0000, "R5");
    access(1'b0, 32'h5100_0000, "R5");
    access(1'b0, 32'h4500_0000, "R2");
    access(1'b0, 32'h2000_1234, "R6");
    access(1'b1, 32'h8000_0000, "R7");
    access(1'b1, 32'h4134_0000, "R8");
    access(1'b0, 32'h3000_0000, "R10");
    access(1'b1, 32'h7FFF_FFFF, "R10");

    // R9: both masters in the same idle cycle
    @(negedge clk);
    int_req = 1'b1; int_addr = 32'h1000_0000;
    ext_req = 1'b1; ext_addr = 32'h2000_0000;
    run_phase(0, m_ws[0], m_ps[0], 1'b0, "R9");
    int_req = 1'b0;
    @(negedge clk);
    check_idle("R9");
    run_phase(3, m_ws[3], m_ps[3], 1'b1, "R9");
    ext_req = 1'b0;
    @(negedge clk);
    check_idle("R9");

    // R11: rewrite the active window mid-access
    @(negedge clk);
    int_req = 1'b1; int_addr = 32'h20AA_0000;
    for (int c = 0; c <= 7; c++) begin
      @(negedge clk);
      chk(ta == (c == 7), "R11", "ta", ta, (c == 7));
      chk(psize == 2'b00, "R11", "psize", psize, 0);
      chk(cs_n == 8'hF7, "R11", "cs_n", cs_n, 8'hF7);
      if (c == 2) begin
        cfg_we = 1'b1; cfg_idx = 3'd3; cfg_valid = 1'b1; cfg_base = 16'h2000;
        cfg_mask = 16'h00FF; cfg_ws = 4'd0; cfg_ps = 2'b10;
      end else begin
        cfg_we = 1'b0;
      end
    end
    int_req = 1'b0;
    m_ws[3] = 0; m_ps[3] = 2'b10;
    @(negedge clk);
    check_idle("R11");
    access(1'b0, 32'h2000_0000, "R11");

    sweep("R2");
    // enable the 4 GB window: every remaining address hits
    cfg_write(6, 1, 16'h0000, 16'hFFFF, 4, 2'b00);
    sweep("R3");

    finish_run();
  end
endmodule